// File: doc/BRIEF.md
# Snapshot-Coherent Event Counter Bank

This block holds a bank of 16-bit up/down event counters behind an 8-bit processor port. Each counter has its own increment, decrement and clear input, and an enable mask register gates counting. The processor reaches a counter one byte at a time. The first byte read from a counter copies the whole counter into a holding register. The read of the other byte is then served from that copy. Software therefore always sees both halves as they stood at one instant, whichever half it reads first and however long the counter keeps counting in between. Accesses to the mask register may be placed between the two halves without disturbing the copy.

A small scheduler keeps processor accesses and counting apart. It has two states. In `ST_OPEN` the port is ready. An accepted access moves it to `ST_SETTLE` for exactly one cycle, and the port is not ready there. It then returns to `ST_OPEN`. During the access cycle the counters are frozen and every count event of that cycle is parked in a per-counter held slot. In the settle cycle the parked events are applied together with that cycle's own events, so the processor always sees a stable value and no event is lost.

Top module: `cnt_snap_bank`

## Requirements
- R1: After reset every counter reads 0, the mask register reads 0 (all counting disabled), `acc_ready` is 1, `acc_rvalid` is 0 and no snapshot is pending.
- R2: An accepted counter read (`acc_mask`=0) with no matching pending snapshot does four things: it returns the addressed byte of the live counter (`acc_hi`=1 selects bits 15:8, 0 selects bits 7:0), copies all 16 bits into the holding register, and records the counter and the byte. The data appears on `acc_rdata` with `acc_rvalid`=1 in the cycle after the access.
- R3: The next counter read that targets the other byte of the pending counter is served from the holding register and ends the snapshot. This holds in both byte orders.
- R4: A counter read of a different counter, or of the same byte again, starts a new snapshot from the live value.
- R5: Accesses with `acc_mask`=1 read or write the enable mask in bits N-1:0 of the data byte, with the upper bits reading 0. They leave the holding register and the pending snapshot unchanged.
- R6: A counter write changes only the addressed byte of the live counter and leaves the holding register unchanged.
- R7: `acc_ready` is 1 in `ST_OPEN` and 0 in the single `ST_SETTLE` cycle after each accepted access. An access presented while `acc_ready`=0 is ignored: it produces no `acc_rvalid` and writes nothing.
- R8: Count events arriving in an access cycle do not change the counter in that cycle. They are applied in the following cycle together with that cycle's own events.
- R9: Within the cycle in which events are applied, each increment adds one and each decrement subtracts one, so an increment and a decrement cancel. Results wrap modulo 65536, and a clear forces the counter to 0 and overrides all counting.
- R10: An increment or decrement of counter i counts only when mask bit i is 1. A clear acts regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Processor access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mask | input | 1 | 1 = mask register, 0 = counter array |
| acc_idx | input | IDXW | Counter select |
| acc_hi | input | 1 | Byte select, 1 = upper byte |
| acc_wdata | input | 8 | Write data |
| acc_ready | output | 1 | Access is accepted this cycle |
| acc_rdata | output | 8 | Read data, registered |
| acc_rvalid | output | 1 | Read data valid |
| ev_inc | input | N | Per-counter increment |
| ev_dec | input | N | Per-counter decrement |
| ev_clr | input | N | Per-counter clear |

## Verification
The directed patterns cover four distinctions:
- Counting continues between two reads of one counter, so a value taken from the holding register differs from the live value in the upper byte. Byte orders low-then-high and high-then-low are both tried.
- A mask read is placed between the two halves. This separates snapshot-preserving accesses from snapshot-restarting ones.
- Reads of a different counter and repeated reads of the same byte show that a new snapshot is started.
- Writes are made during a pending snapshot and accesses are presented during the settle cycle, so write-through and ignore behaviour are separated.

Count patterns cover several cases: events that coincide with an access, inc and dec together, wrap at both ends, clear against a pending increment, and masked counters. These expose lost or doubled events. Seeded random traffic then mixes all of these against a bench model of the requirements.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_SETTLE = 1'b1
    } sched_state_e;
endpackage

// File: rtl/cnt_sched.sv
module cnt_sched
    import cnt_snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    output logic ready,
    output logic take
);
    sched_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        take    = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                ready = 1'b1;
                if (acc_valid) begin
                    take    = 1'b1;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end
endmodule

// File: rtl/cnt_cell.sv
module cnt_cell
    import cnt_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              inc,
    input  logic              dec,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  value
);
    logic             held_inc, held_dec, held_clr;
    logic [1:0]       n_up, n_down;
    logic [CNT_W-1:0] next_val;

    always_comb begin
        n_up     = {1'b0, held_inc} + {1'b0, inc};
        n_down   = {1'b0, held_dec} + {1'b0, dec};
        next_val = value + CNT_W'(n_up) - CNT_W'(n_down);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value    <= '0;
            held_inc <= 1'b0;
            held_dec <= 1'b0;
            held_clr <= 1'b0;
        end else if (freeze) begin
            held_inc <= inc;
            held_dec <= dec;
            held_clr <= clr;
            if (wr_lo) value[BYTE_W-1:0]     <= wdata;
            if (wr_hi) value[CNT_W-1:BYTE_W] <= wdata;
        end else begin
            value    <= (held_clr || clr) ? '0 : next_val;
            held_inc <= 1'b0;
            held_dec <= 1'b0;
            held_clr <= 1'b0;
        end
    end
endmodule

// File: rtl/snap_hold.sv
module snap_hold
    import cnt_snap_pkg::*;
#(
    parameter int IDXW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cnt,
    input  logic [IDXW-1:0]   rd_idx,
    input  logic              rd_hi,
    input  logic [CNT_W-1:0]  live,
    output logic [BYTE_W-1:0] byte_out,
    output logic [CNT_W-1:0]  hold_q
);
    logic            pend_q;
    logic [IDXW-1:0] pend_idx_q;
    logic            pend_hi_q;
    logic            from_hold;

    always_comb begin
        from_hold = pend_q && (pend_idx_q == rd_idx) && (pend_hi_q != rd_hi);
        if (from_hold) byte_out = rd_hi ? hold_q[CNT_W-1:BYTE_W] : hold_q[BYTE_W-1:0];
        else           byte_out = rd_hi ? live[CNT_W-1:BYTE_W]   : live[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            pend_hi_q  <= 1'b0;
            hold_q     <= '0;
        end else if (rd_cnt) begin
            if (from_hold) begin
                pend_q <= 1'b0;
            end else begin
                hold_q     <= live;
                pend_q     <= 1'b1;
                pend_idx_q <= rd_idx;
                pend_hi_q  <= rd_hi;
            end
        end
    end
endmodule

// File: rtl/cnt_snap_bank.sv
module cnt_snap_bank
    import cnt_snap_pkg::*;
#(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_mask,
    input  logic [IDXW-1:0]   acc_idx,
    input  logic              acc_hi,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic              acc_rvalid,
    input  logic [N-1:0]      ev_inc,
    input  logic [N-1:0]      ev_dec,
    input  logic [N-1:0]      ev_clr
);
    logic                take;
    logic [N-1:0]        mask_q;
    logic [N*CNT_W-1:0]  cnt_flat;
    logic [CNT_W-1:0]    live;
    logic [CNT_W-1:0]    hold_q;
    logic [BYTE_W-1:0]   snap_byte;
    logic [BYTE_W-1:0]   mask_byte;
    logic [BYTE_W-1:0]   rd_byte;
    logic                idx_ok;
    logic                rd_cnt;

    cnt_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .ready     (acc_ready),
        .take      (take)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_cell
        logic wsel;
        assign wsel = take && acc_write && !acc_mask && (int'(acc_idx) == gi);
        cnt_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .freeze (take),
            .inc    (ev_inc[gi] & mask_q[gi]),
            .dec    (ev_dec[gi] & mask_q[gi]),
            .clr    (ev_clr[gi]),
            .wr_lo  (wsel && !acc_hi),
            .wr_hi  (wsel && acc_hi),
            .wdata  (acc_wdata),
            .value  (cnt_flat[gi*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        idx_ok = int'(acc_idx) < N;
        live   = '0;
        for (int i = 0; i < N; i++)
            if (int'(acc_idx) == i) live = cnt_flat[i*CNT_W +: CNT_W];
        mask_byte         = '0;
        mask_byte[N-1:0]  = mask_q;
        rd_cnt            = take && !acc_write && !acc_mask && idx_ok;
        rd_byte           = acc_mask ? mask_byte : (idx_ok ? snap_byte : '0);
    end

    snap_hold #(.IDXW(IDXW)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cnt   (rd_cnt),
        .rd_idx   (acc_idx),
        .rd_hi    (acc_hi),
        .live     (live),
        .byte_out (snap_byte),
        .hold_q   (hold_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '0;
            acc_rdata  <= '0;
            acc_rvalid <= 1'b0;
        end else begin
            acc_rvalid <= take && !acc_write;
            if (take && !acc_write) acc_rdata <= rd_byte;
            if (take && acc_write && acc_mask) mask_q <= acc_wdata[N-1:0];
        end
    end
endmodule

// File: rtl/cnt_snap_bank_chk.sv
module cnt_snap_bank_chk
    import cnt_snap_pkg::*;
#(
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_ready,
    input logic               acc_write,
    input logic               acc_mask,
    input logic               acc_rvalid,
    input logic [N*CNT_W-1:0] cnt_flat,
    input logic [CNT_W-1:0]   hold_q
);
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    p_settle_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |=> acc_ready);

    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write) |=> acc_rvalid);

    p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready && !acc_write) |=> !acc_rvalid);

    p_frozen_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write) |=> $stable(cnt_flat));

    p_hold_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_write) |=> $stable(hold_q));

    p_hold_on_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_mask) |=> $stable(hold_q));
endmodule

bind cnt_snap_bank cnt_snap_bank_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_write  (acc_write),
    .acc_mask   (acc_mask),
    .acc_rvalid (acc_rvalid),
    .cnt_flat   (cnt_flat),
    .hold_q     (hold_q)
);

// File: tb/cnt_snap_bank_bench.sv
module cnt_snap_bank_bench;
    localparam int N    = 4;
    localparam int IDXW = 2;
    localparam time CLK_P = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0, acc_write = 1'b0, acc_mask = 1'b0, acc_hi = 1'b0;
    logic [IDXW-1:0] acc_idx = '0;
    logic [7:0]      acc_wdata = '0;
    logic            acc_ready, acc_rvalid;
    logic [7:0]      acc_rdata;
    logic [N-1:0]    ev_inc = '0, ev_dec = '0, ev_clr = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model of the requirements
    logic [15:0] m_cnt [N];
    logic [N-1:0] m_mask;
    logic [N-1:0] m_hinc, m_hdec, m_hclr;
    bit          m_open;
    bit          s_vld;
    int          s_idx;
    bit          s_hi;
    logic [15:0] s_hold;

    always #(CLK_P/2) clk = ~clk;

    cnt_snap_bank #(.N(N)) u_cnt_snap_bank (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_mask(acc_mask), .acc_idx(acc_idx), .acc_hi(acc_hi), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
        .ev_inc(ev_inc), .ev_dec(ev_dec), .ev_clr(ev_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pick(input logic [15:0] v, input bit hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_mask = '0; m_hinc = '0; m_hdec = '0; m_hclr = '0;
        m_open = 1'b1; s_vld = 1'b0; s_idx = 0; s_hi = 1'b0; s_hold = '0;
    endtask

    // one clock cycle of stimulus, checked against the model
    task automatic step(input bit v, input bit w, input bit m, input int idx, input bit hi,
                        input logic [7:0] wd, input logic [N-1:0] inc, input logic [N-1:0] dec,
                        input logic [N-1:0] clr, input string tag);
        bit          acc;
        bit          exp_rv;
        logic [7:0]  exp_rd;
        logic [7:0]  mb;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_mask = m; acc_idx = IDXW'(idx);
        acc_hi = hi; acc_wdata = wd; ev_inc = inc; ev_dec = dec; ev_clr = clr;
        chk("R7 ready", int'(acc_ready), int'(m_open));
        acc    = v && m_open;
        exp_rv = acc && !w;
        exp_rd = '0;
        if (acc) begin
            m_hinc = inc & m_mask; m_hdec = dec & m_mask; m_hclr = clr;
            if (m) begin
                mb = '0; mb[N-1:0] = m_mask;
                if (w) m_mask = wd[N-1:0];
                else   exp_rd = mb;
            end else if (w) begin
                if (hi) m_cnt[idx][15:8] = wd; else m_cnt[idx][7:0] = wd;
            end else if (s_vld && s_idx == idx && s_hi != hi) begin
                exp_rd = pick(s_hold, hi);
                s_vld  = 1'b0;
            end else begin
                s_hold = m_cnt[idx]; s_vld = 1'b1; s_idx = idx; s_hi = hi;
                exp_rd = pick(s_hold, hi);
            end
            m_open = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_hclr[i] || clr[i]) m_cnt[i] = '0;
                else m_cnt[i] = m_cnt[i] + 16'(m_hinc[i] + (inc[i] & m_mask[i]))
                                        - 16'(m_hdec[i] + (dec[i] & m_mask[i]));
            end
            m_hinc = '0; m_hdec = '0; m_hclr = '0;
            m_open = 1'b1;
        end
        @(posedge clk);
        #1;
        chk({tag, " rvalid"}, int'(acc_rvalid), int'(exp_rv));
        if (exp_rv) chk({tag, " rdata"}, int'(acc_rdata), int'(exp_rd));
    endtask

    task automatic idle(input int n, input logic [N-1:0] inc);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 8'h00, inc, '0, '0, "R9");
    endtask

    task automatic rd(input bit m, input int idx, input bit hi, input string tag);
        step(1, 0, m, idx, hi, 8'h00, '0, '0, '0, tag);
        idle(1, '0);
    endtask

    task automatic wr(input bit m, input int idx, input bit hi, input logic [7:0] d, input string tag);
        step(1, 1, m, idx, hi, d, '0, '0, '0, tag);
        idle(1, '0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", int'(acc_ready), 1);
        chk("R1 rvalid", int'(acc_rvalid), 0);
        chk("R1 rdata", int'(acc_rdata), 0);
        for (int i = 0; i < N; i++) rd(0, i, 1, "R1");
        rd(1, 0, 0, "R1");
        // R10 masked counter does not count before enabling
        idle(3, 4'b0010);
        rd(0, 1, 0, "R10");
        wr(1, 0, 0, 8'h0F, "R5");
        rd(1, 0, 0, "R5");
        // R2 / R3 low first with counting and mask read in between
        idle(300, 4'b0010);
        rd(0, 1, 0, "R2");
        idle(300, 4'b0010);
        rd(1, 0, 0, "R5");
        rd(0, 1, 1, "R3");
        // R3 high first
        rd(0, 1, 1, "R2");
        idle(100, 4'b0010);
        rd(0, 1, 0, "R3");
        // R4 other counter restarts
        rd(0, 1, 0, "R2");
        idle(256, 4'b0010);
        rd(0, 2, 0, "R4");
        rd(0, 1, 1, "R4");
        rd(0, 1, 1, "R4");
        // R6 write during pending snapshot
        rd(0, 1, 0, "R6");
        wr(0, 1, 1, 8'hAA, "R6");
        rd(0, 1, 1, "R6");
        rd(0, 1, 1, "R6");
        // R7 access in settle cycle ignored
        step(1, 0, 0, 0, 0, 8'h00, '0, '0, '0, "R7");
        step(1, 1, 0, 0, 0, 8'h55, '0, '0, '0, "R7");
        rd(0, 0, 0, "R7");
        // R8 event during access
        step(1, 0, 0, 2, 0, 8'h00, 4'b0100, '0, '0, "R8");
        step(0, 0, 0, 0, 0, 8'h00, 4'b0100, '0, '0, "R8");
        rd(0, 2, 0, "R8");
        // R9 wrap, cancel, clear
        wr(0, 3, 0, 8'hFF, "R9");
        wr(0, 3, 1, 8'hFF, "R9");
        idle(1, 4'b1000);
        rd(0, 3, 0, "R9");
        step(0, 0, 0, 0, 0, 8'h00, '0, 4'b1000, '0, "R9");
        rd(0, 3, 1, "R9");
        step(0, 0, 0, 0, 0, 8'h00, 4'b1000, 4'b1000, '0, "R9");
        rd(0, 3, 0, "R9");
        step(1, 0, 1, 0, 0, 8'h00, 4'b1000, '0, 4'b1000, "R9");
        idle(1, '0);
        rd(0, 3, 0, "R9");
        // R10 disabled counter ignores counting, clear still works
        wr(1, 0, 0, 8'h07, "R10");
        idle(5, 4'b1000);
        rd(0, 3, 0, "R10");
        idle(1, 4'b0001);
        step(0, 0, 0, 0, 0, 8'h00, '0, '0, 4'b0001, "R10");
        rd(0, 0, 0, "R10");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            bit v, w, m;
            v = ($urandom % 3) == 0;
            w = ($urandom % 4) == 0;
            m = ($urandom % 6) == 0;
            step(v, w, m, int'($urandom % N), 1'($urandom), 8'($urandom),
                 N'($urandom), N'($urandom % 4 == 0 ? $urandom : 0),
                 N'($urandom % 16 == 0 ? $urandom : 0), "R3 random");
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule